// File: doc/BRIEF.md
# Interrupt Priority Mask Filter

This block decides, cycle by cycle, whether an incoming interrupt request gets past the processor's current interrupt priority mask. An external source presents a requested priority level. The status register supplies a mask of the same width, which is its three-bit field at bits 10 down to 8. Level 0 stands for "no request". The highest level (7 with the default width) cannot be masked. It is taken on its rising transition, not on its level.

Levels 1 to 6 pass whenever they are strictly above the mask. A pass is reported on every cycle in which this holds. Lowering the request after it has been serviced is left to the logic around the block. The highest level produces exactly one accept each time the request moves into it from any lower value. After reset, a highest-level request that is already present counts as a fresh transition. Both outputs are registered: the accept pulse and the accepted level appear together, one clock after the inputs that caused them.

Top module: `irq_mask_gate`

## Requirements
- R1: While `rst_n` is low, `accept` is 0 and `accept_lvl` is 0; asserting reset clears them at once (asynchronous).
- R2: A requested level of 0 never produces an accept, whatever the mask.
- R3: For a requested level L in 1..6 with L strictly greater than the mask, `accept` is 1 on the clock edge after the one that sampled the request. This repeats on every cycle for which the condition holds.
- R4: For a requested level L in 1..6 with L less than or equal to the mask, `accept` stays 0.
- R5: A requested level of 7 is accepted whatever the mask, including a mask of 7.
- R6: Level 7 is accepted only on the first sampled cycle after the request was below 7. While the request stays at 7 it is not accepted again, until it has dropped below 7 and returned.
- R7: `accept_lvl` equals the accepted requested level in the same cycle that `accept` is 1, and is 0 whenever `accept` is 0.
- R8: Reset clears the transition history. A level-7 request present when reset is released is accepted on the first sampling edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lvl | input | 3 | Requested priority level, 0 = none, 7 = non-maskable |
| ipl_mask | input | 3 | Current priority mask from the status register |
| accept | output | 1 | Registered accept pulse |
| accept_lvl | output | 3 | Level accepted, valid with `accept`, otherwise 0 |

## Verification
The assertions assume that `req_lvl` and `ipl_mask` are stable around each rising edge and are never unknown once reset is released. For the first two edges after release, the checker counts the edges instead of relying on pre-reset history. The bench changes the inputs only on falling edges and holds both at defined values from time zero, including during reset. Each sequence of level-7 requests is written so that the bench can tell a transition into 7 from a held 7.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  // Default request/mask width; the top-level parameter overrides it.
  localparam int unsigned LVL_W_DEF = 3;

  // Highest (non-maskable) level for a given width.
  function automatic int unsigned top_level(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // True when lvl is the non-maskable level.
  function automatic logic is_top(input int unsigned lvl, input int unsigned top);
    return lvl == top;
  endfunction

  // True for an ordinary (maskable) request that beats the mask.
  function automatic logic beats_mask(input int unsigned lvl,
                                      input int unsigned msk,
                                      input int unsigned top);
    return (lvl != 0) && (lvl != top) && (lvl > msk);
  endfunction

endpackage

// File: rtl/irqf_level_cmp.sv
module irqf_level_cmp
  import irqf_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] mask,
  output logic             pass_o
);
  localparam int unsigned TOP = top_level(LVL_W);

  always_comb begin
    pass_o = beats_mask(32'(req_lvl), 32'(mask), TOP);
  end
endmodule

// File: rtl/irqf_nmi_edge.sv
module irqf_nmi_edge
  import irqf_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             edge_o
);
  localparam int unsigned TOP = top_level(LVL_W);

  logic at_top;
  logic was_top_q;

  always_comb begin
    at_top = is_top(32'(req_lvl), TOP);
    edge_o = at_top && !was_top_q;
  end

  // History cleared by reset so a held top level counts as new.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_top_q <= 1'b0;
    else        was_top_q <= at_top;
  end
endmodule

// File: rtl/irqf_out_reg.sv
module irqf_out_reg #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LVL_W-1:0] lvl,
  output logic             accept,
  output logic [LVL_W-1:0] accept_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      accept_lvl <= '0;
    end else begin
      accept     <= take;
      accept_lvl <= take ? lvl : '0;
    end
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
  import irqf_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] ipl_mask,
  output logic             accept,
  output logic [LVL_W-1:0] accept_lvl
);
  // Named internal events, visible to the bound checker.
  logic lvl_pass;
  logic nmi_edge;
  logic take;

  irqf_level_cmp #(.LVL_W(LVL_W)) cmp_i (
    .req_lvl (req_lvl),
    .mask    (ipl_mask),
    .pass_o  (lvl_pass)
  );

  irqf_nmi_edge #(.LVL_W(LVL_W)) nmi_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_lvl (req_lvl),
    .edge_o  (nmi_edge)
  );

  assign take = lvl_pass | nmi_edge;

  irqf_out_reg #(.LVL_W(LVL_W)) out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .lvl        (req_lvl),
    .accept     (accept),
    .accept_lvl (accept_lvl)
  );
endmodule

module irq_mask_gate_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] req_lvl,
  input logic [LVL_W-1:0] ipl_mask,
  input logic             accept,
  input logic [LVL_W-1:0] accept_lvl,
  input logic             lvl_pass,
  input logic             nmi_edge
);
  localparam logic [LVL_W-1:0] TOP = '1;

  // Edges seen since reset release: guards every $past.
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= 2'd0;
    else if (seen != 3) seen <= seen + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (!accept && accept_lvl == '0);
  end

  assert_idle_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 0 && $past(req_lvl) == '0) |-> !accept);

  assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 0 && $past(req_lvl) != '0 && $past(req_lvl) != TOP &&
     $past(req_lvl) > $past(ipl_mask)) |-> (accept && accept_lvl == $past(req_lvl)));

  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 0 && $past(req_lvl) != '0 && $past(req_lvl) != TOP &&
     $past(req_lvl) <= $past(ipl_mask)) |-> !accept);

  assert_top_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && $past(req_lvl) == TOP && $past(req_lvl, 2) != TOP)
      |-> (accept && accept_lvl == TOP));

  assert_top_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && $past(req_lvl) == TOP && $past(req_lvl, 2) == TOP) |-> !accept);

  assert_lvl_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> accept_lvl == '0);

  assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lvl_pass, nmi_edge}));

  assert_reset_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 1 && $past(req_lvl) == TOP) |-> (accept && accept_lvl == TOP));
endmodule

bind irq_mask_gate irq_mask_gate_chk #(.LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_lvl    (req_lvl),
  .ipl_mask   (ipl_mask),
  .accept     (accept),
  .accept_lvl (accept_lvl),
  .lvl_pass   (lvl_pass),
  .nmi_edge   (nmi_edge)
);

// File: tb/irq_mask_gate_tb.sv
module irq_mask_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_lvl = 3'd0;
  logic [2:0] ipl_mask = 3'd0;
  logic       accept;
  logic [2:0] accept_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_mask_gate dut_i (
    .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .ipl_mask(ipl_mask),
    .accept(accept), .accept_lvl(accept_lvl)
  );

  typedef struct packed {
    logic [2:0] req;
    logic [2:0] msk;
    logic       acc;
    logic [2:0] lvl;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 1'b0, 3'd0, 4'd2},  // R2 idle
    '{3'd3, 3'd2, 1'b1, 3'd3, 4'd3},  // R3 above mask
    '{3'd3, 3'd2, 1'b1, 3'd3, 4'd3},  // R3 repeats while held
    '{3'd3, 3'd3, 1'b0, 3'd0, 4'd4},  // R4 equal to mask
    '{3'd2, 3'd5, 1'b0, 3'd0, 4'd4},  // R4 below mask
    '{3'd6, 3'd5, 1'b1, 3'd6, 4'd3},  // R3
    '{3'd6, 3'd6, 1'b0, 3'd0, 4'd4},  // R4
    '{3'd1, 3'd0, 1'b1, 3'd1, 4'd7},  // R7 level reported
    '{3'd0, 3'd7, 1'b0, 3'd0, 4'd2},  // R2
    '{3'd7, 3'd7, 1'b1, 3'd7, 4'd5},  // R5 mask 7 cannot block
    '{3'd7, 3'd7, 1'b0, 3'd0, 4'd6},  // R6 held
    '{3'd7, 3'd0, 1'b0, 3'd0, 4'd6},  // R6 held, mask irrelevant
    '{3'd6, 3'd7, 1'b0, 3'd0, 4'd4},  // R4 and drop below 7
    '{3'd7, 3'd7, 1'b1, 3'd7, 4'd6},  // R6 re-entry
    '{3'd0, 3'd0, 1'b0, 3'd0, 4'd2},  // R2
    '{3'd7, 3'd3, 1'b1, 3'd7, 4'd5},  // R5
    '{3'd5, 3'd3, 1'b1, 3'd5, 4'd3},  // R3
    '{3'd7, 3'd3, 1'b1, 3'd7, 4'd6}   // R6 re-entry from 5
  };

  task automatic check(input string tag, input logic a, input logic [2:0] l,
                       input logic ea, input logic [2:0] el);
    checks++;
    if (a !== ea || l !== el) begin
      errors++;
      $display("FAIL %s: accept=%0b lvl=%0d expected accept=%0b lvl=%0d",
               tag, a, l, ea, el);
    end
  endtask

  task automatic step(input logic [2:0] r, input logic [2:0] m);
    req_lvl  = r;
    ipl_mask = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: outputs clear during reset
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", accept, accept_lvl, 1'b0, 3'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      step(VECS[i].req, VECS[i].msk);
      check($sformatf("R%0d vec %0d", VECS[i].rq, i), accept, accept_lvl,
            VECS[i].acc, VECS[i].lvl);
    end

    // R1: asynchronous clear while an accept is showing
    @(negedge clk); step(3'd5, 3'd0);
    check("R3 before reset", accept, accept_lvl, 1'b1, 3'd5);
    #0.5 rst_n = 1'b0;
    #0.5 check("R1 async clear", accept, accept_lvl, 1'b0, 3'd0);

    // R8: level 7 held through reset counts as new edge
    @(negedge clk); req_lvl = 3'd7; ipl_mask = 3'd7;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 edge after reset", accept, accept_lvl, 1'b1, 3'd7);
    @(posedge clk); #1;
    check("R6 held after reset", accept, accept_lvl, 1'b0, 3'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 second release", accept, accept_lvl, 1'b1, 3'd7);

    // R2: zero against every mask value
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); step(3'd0, 3'(m));
      check("R2 zero sweep", accept, accept_lvl, 1'b0, 3'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule